// File: doc/BRIEF.md
# Third-Order Fractional-N Division Ratio Modulator

This block generates the per-cycle integer division ratio for the feedback divider of a fractional-N frequency synthesizer. It advances once per phase-detector cycle. Each cycle it emits an integer close to the programmed ratio. Over a long run, the mean of those integers equals INT + (FRAC1 + FRAC2/MOD2) / 2^F1_W exactly.

Two kinds of accumulator produce the fractional part. The first is an auxiliary accumulator whose modulus is programmable. Each time it wraps, it adds one least-significant count to the primary fractional numerator for that cycle. The second is a cascade of three power-of-two accumulators, which shapes the quantisation noise to third order. The cascade's combined carry term lies between -3 and +4 and is added to the integer part.

A single load strobe captures all settings together and restarts the accumulators from zero. Any setting outside its legal range raises an error flag and freezes the output.

Top module: `fracn_mod3`

## Requirements
- R1: After reset, and until the first legal load, div_out is 0 and cfg_err is 1.
- R2: Settings are taken only on a cycle with load high. At all other times, changes on int_in, frac1_in, frac2_in, mod2_in and presc_sel have no effect on div_out or cfg_err.
- R3: On the output sampled after a legal load, div_out equals the loaded INT and cfg_err is 0.
- R4: While cfg_err is 0, every div_out value lies in INT-3 to INT+4.
- R5: After a legal load, consider the MOD2*2^F1_W outputs that follow the first post-load value. Their sum minus INT times that count differs from FRAC1*MOD2 + FRAC2 by at most 2. Over twice that many outputs, it differs from twice that value by at most 2, so the error does not grow.
- R6: With FRAC1 = 0 and FRAC2 = 0, div_out equals INT on every cycle.
- R7: A load is illegal when any of the following holds:
  - presc_sel = 0 (narrow prescaler) and INT is below 23 or above 32767;
  - presc_sel = 1 (wide prescaler) and INT is below 75;
  - MOD2 is below 2;
  - FRAC2 is equal to or greater than MOD2.

  An illegal load sets cfg_err to 1. A legal load clears it. The boundary values 23, 32767, 75 and 65535 are legal.
- R8: After an illegal load, div_out keeps the value it had before that load. It stays constant until the next legal load.
- R9: A load clears all accumulator and delay state. The output sequence after a reload matches the sequence produced after an earlier load of the same settings, whatever state the block was in when the reload arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture all settings and clear the accumulators |
| int_in | input | INT_W | Integer part of the ratio |
| frac1_in | input | F1_W | Primary fractional numerator over 2^F1_W |
| frac2_in | input | F2_W | Auxiliary numerator |
| mod2_in | input | F2_W | Auxiliary modulus |
| presc_sel | input | 1 | 0 selects the narrow prescaler limits, 1 the wide ones |
| div_out | output | INT_W+1 | Division ratio for the current cycle |
| cfg_err | output | 1 | Last loaded settings are illegal |

## Verification
A load can land on a cycle in which the accumulators would otherwise advance, including a cycle in which the auxiliary accumulator wraps and carries into the primary cascade. The load must win. To provoke this, the bench records the first outputs after loading a fractional setting, runs the block for an odd number of further cycles so that the state is mid-sequence, then reloads the same setting and compares the new sequence with the recorded one. A second collision is an illegal load arriving while the block is producing a varying output. The bench judges it by comparing the value sampled just before the load with every value sampled afterwards.

// File: rtl/fnm_pkg.sv
package fnm_pkg;
    // Prescaler choice: selects which INT window is legal
    typedef enum logic {
        PRESC_NARROW = 1'b0,
        PRESC_WIDE   = 1'b1
    } presc_e;

    // Shaped correction term, range -3..+4
    localparam int SHAPE_W = 4;
    typedef logic signed [SHAPE_W-1:0] shaped_t;
endpackage

// File: rtl/fnm_cfg_check.sv
module fnm_cfg_check #(
    parameter int INT_W      = 16,
    parameter int F2_W       = 28,
    parameter int INT_MIN_NR = 23,
    parameter int INT_MAX_NR = 32767,
    parameter int INT_MIN_WD = 75
) (
    input  logic [INT_W-1:0] int_v,
    input  logic [F2_W-1:0]  frac2,
    input  logic [F2_W-1:0]  mod2,
    input  logic             presc,
    output logic             legal
);
    import fnm_pkg::*;

    localparam logic [INT_W-1:0] MIN_NR  = INT_W'(INT_MIN_NR);
    localparam logic [INT_W-1:0] MAX_NR  = INT_W'(INT_MAX_NR);
    localparam logic [INT_W-1:0] MIN_WD  = INT_W'(INT_MIN_WD);
    localparam logic [F2_W-1:0]  MOD_MIN = F2_W'(2);

    logic int_ok;
    logic mod_ok;
    logic num_ok;

    always_comb begin
        if (presc_e'(presc) == PRESC_WIDE) begin
            int_ok = (int_v >= MIN_WD);
        end else begin
            int_ok = (int_v >= MIN_NR) && (int_v <= MAX_NR);
        end
        mod_ok = (mod2 >= MOD_MIN);
        num_ok = (frac2 < mod2);
        legal  = int_ok && mod_ok && num_ok;
    end
endmodule

// File: rtl/fnm_aux_acc.sv
module fnm_aux_acc #(
    parameter int F2_W = 28
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            en,
    input  logic [F2_W-1:0] frac2,
    input  logic [F2_W-1:0] mod2,
    output logic            carry,
    output logic [F2_W-1:0] acc
);
    typedef struct packed {
        logic [F2_W-1:0] acc;
    } aux_st_t;

    aux_st_t    st_d, st_q;
    logic [F2_W:0] sum_w;
    logic [F2_W:0] wrap_w;

    always_comb begin
        sum_w  = {1'b0, st_q.acc} + {1'b0, frac2};
        wrap_w = sum_w - {1'b0, mod2};
        carry  = (sum_w >= {1'b0, mod2});
        st_d   = st_q;
        if (clr) begin
            st_d.acc = '0;
        end else if (en) begin
            st_d.acc = carry ? wrap_w[F2_W-1:0] : sum_w[F2_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc = st_q.acc;

    // residue stays below a legal modulus
    assert_aux_lt_mod_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mod2 >= F2_W'(2)) |-> (st_q.acc < mod2));
endmodule

// File: rtl/fnm_mash3.sv
module fnm_mash3 #(
    parameter int F1_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            en,
    input  logic [F1_W-1:0] frac1,
    input  logic            cin,
    output fnm_pkg::shaped_t y
);
    import fnm_pkg::*;

    typedef struct packed {
        logic [F1_W-1:0] a;
        logic [F1_W-1:0] b;
        logic [F1_W-1:0] c;
        logic            c2_d1;
        logic            c3_d1;
        logic            c3_d2;
    } mash_st_t;

    mash_st_t st_d, st_q;
    logic [F1_W:0] s1, s2, s3;
    logic          c1, c2, c3;

    always_comb begin
        s1 = {1'b0, st_q.a} + {1'b0, frac1} + {{F1_W{1'b0}}, cin};
        c1 = s1[F1_W];
        s2 = {1'b0, st_q.b} + {1'b0, s1[F1_W-1:0]};
        c2 = s2[F1_W];
        s3 = {1'b0, st_q.c} + {1'b0, s2[F1_W-1:0]};
        c3 = s3[F1_W];

        y = shaped_t'({3'b000, c1})
          + shaped_t'({3'b000, c2})
          - shaped_t'({3'b000, st_q.c2_d1})
          + shaped_t'({3'b000, c3})
          - shaped_t'({2'b00, st_q.c3_d1, 1'b0})
          + shaped_t'({3'b000, st_q.c3_d2});

        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (en) begin
            st_d.a     = s1[F1_W-1:0];
            st_d.b     = s2[F1_W-1:0];
            st_d.c     = s3[F1_W-1:0];
            st_d.c2_d1 = c2;
            st_d.c3_d1 = c3;
            st_d.c3_d2 = st_q.c3_d1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // a load empties the whole cascade
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.a == '0 && st_q.b == '0 && st_q.c == '0
                 && !st_q.c2_d1 && !st_q.c3_d1 && !st_q.c3_d2));

    // zero input keeps an empty cascade empty
    assert_zero_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && frac1 == '0 && !cin && st_q.a == '0 && st_q.b == '0
         && st_q.c == '0 && !st_q.c2_d1 && !st_q.c3_d1 && !st_q.c3_d2)
        |=> (st_q.a == '0 && st_q.b == '0 && st_q.c == '0));
endmodule

// File: rtl/fracn_mod3.sv
module fracn_mod3 #(
    parameter int INT_W      = 16,
    parameter int F1_W       = 24,
    parameter int F2_W       = 28,
    parameter int INT_MIN_NR = 23,
    parameter int INT_MAX_NR = 32767,
    parameter int INT_MIN_WD = 75
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [INT_W-1:0] int_in,
    input  logic [F1_W-1:0]  frac1_in,
    input  logic [F2_W-1:0]  frac2_in,
    input  logic [F2_W-1:0]  mod2_in,
    input  logic             presc_sel,
    output logic [INT_W:0]   div_out,
    output logic             cfg_err
);
    import fnm_pkg::*;

    localparam int OUT_W = INT_W + 1;
    localparam int SUM_W = INT_W + 2;

    typedef struct packed {
        logic [INT_W-1:0] int_v;
        logic [F1_W-1:0]  frac1;
        logic [F2_W-1:0]  frac2;
        logic [F2_W-1:0]  mod2;
        logic             err;
        logic [OUT_W-1:0] div;
    } top_st_t;

    top_st_t st_d, st_q;

    logic             legal_new;
    logic             run_en;
    logic             aux_carry;
    logic [F2_W-1:0]  aux_res;
    shaped_t          shape;
    logic signed [SUM_W-1:0] sum_w;

    fnm_cfg_check #(
        .INT_W      (INT_W),
        .F2_W       (F2_W),
        .INT_MIN_NR (INT_MIN_NR),
        .INT_MAX_NR (INT_MAX_NR),
        .INT_MIN_WD (INT_MIN_WD)
    ) u_check (
        .int_v (int_in),
        .frac2 (frac2_in),
        .mod2  (mod2_in),
        .presc (presc_sel),
        .legal (legal_new)
    );

    assign run_en = !load && !st_q.err;

    fnm_aux_acc #(.F2_W(F2_W)) u_aux (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load),
        .en    (run_en),
        .frac2 (st_q.frac2),
        .mod2  (st_q.mod2),
        .carry (aux_carry),
        .acc   (aux_res)
    );

    fnm_mash3 #(.F1_W(F1_W)) u_mash (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load),
        .en    (run_en),
        .frac1 (st_q.frac1),
        .cin   (aux_carry),
        .y     (shape)
    );

    always_comb begin
        sum_w = $signed({2'b00, st_q.int_v})
              + $signed({{(SUM_W-SHAPE_W){shape[SHAPE_W-1]}}, shape});
        st_d = st_q;
        if (load) begin
            st_d.int_v = int_in;
            st_d.frac1 = frac1_in;
            st_d.frac2 = frac2_in;
            st_d.mod2  = mod2_in;
            st_d.err   = !legal_new;
            if (legal_new) begin
                st_d.div = {1'b0, int_in};
            end
        end else if (!st_q.err) begin
            st_d.div = sum_w[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.err <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_out = st_q.div;
    assign cfg_err = st_q.err;

    // output stays inside the shaped window around INT
    assert_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.err |-> (int'(st_q.div) >= int'(st_q.int_v) - 3
                       && int'(st_q.div) <= int'(st_q.int_v) + 4));

    // frozen output while settings are illegal
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err && !load) |=> $stable(st_q.div));

    // flag changes only on a load
    assert_flag_only_on_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(st_q.err));

    // zero fraction gives plain INT
    assert_zero_frac_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.err && st_q.frac1 == '0 && st_q.frac2 == '0)
        |-> (st_q.div == {1'b0, st_q.int_v}));

    // unused residue is observed only through assertions above
    logic unused_res;
    assign unused_res = ^aux_res;
endmodule

// File: tb/sim_fracn_mod3.sv
module sim_fracn_mod3;
    localparam int CLK_PERIOD = 10;
    localparam int INT_W = 16;
    localparam int F1_W  = 4;
    localparam int F2_W  = 4;
    localparam int ONE1  = 1 << F1_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             load = 1'b0;
    logic [INT_W-1:0] int_in = '0;
    logic [F1_W-1:0]  frac1_in = '0;
    logic [F2_W-1:0]  frac2_in = '0;
    logic [F2_W-1:0]  mod2_in = '0;
    logic             presc_sel = 1'b0;
    logic [INT_W:0]   div_out;
    logic             cfg_err;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fracn_mod3 #(.INT_W(INT_W), .F1_W(F1_W), .F2_W(F2_W)) u0 (
        .clk(clk), .rst_n(rst_n), .load(load), .int_in(int_in),
        .frac1_in(frac1_in), .frac2_in(frac2_in), .mod2_in(mod2_in),
        .presc_sel(presc_sel), .div_out(div_out), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive at a falling edge, capture on the rising edge, return at the next falling edge
    task automatic do_load(input int iv, input int f1, input int f2, input int m2, input bit ps);
        int_in    = INT_W'(iv);
        frac1_in  = F1_W'(f1);
        frac2_in  = F2_W'(f2);
        mod2_in   = F2_W'(m2);
        presc_sel = ps;
        load      = 1'b1;
        @(negedge clk);
        load      = 1'b0;
    endtask

    // sum of (div_out - INT) over n cycles; counts out-of-window samples
    task automatic run_sum(input int iv, input int n, output int s, output int bad);
        s = 0;
        bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            s += int'(div_out) - iv;
            if (int'(div_out) < iv - 3 || int'(div_out) > iv + 4) bad++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_errs++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        int s, bad, s2, bad2, hold_v, moved, expv;
        int mods[4] = '{2, 3, 7, 13};
        int f1s[4]  = '{0, 1, 6, 15};
        int seq_a[24];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(div_out == '0, "R1 div_out after reset", int'(div_out), 0);
        check(cfg_err == 1'b1, "R1 cfg_err after reset", int'(cfg_err), 1);

        // R3, R6: zero fraction
        do_load(100, 0, 0, 2, 1'b0);
        check(cfg_err == 1'b0, "R3 cfg_err after legal load", int'(cfg_err), 0);
        check(int'(div_out) == 100, "R3 first value is INT", int'(div_out), 100);
        moved = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (int'(div_out) != 100) moved++;
        end
        check(moved == 0, "R6 zero fraction gives INT", moved, 0);

        // R2: inputs without load are ignored
        int_in = 16'd200; frac1_in = 4'd5; frac2_in = 4'd1; mod2_in = 4'd1; presc_sel = 1'b1;
        moved = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (int'(div_out) != 100 || cfg_err) moved++;
        end
        check(moved == 0, "R2 unloaded inputs ignored", moved, 0);

        // R4, R5: sweep of fractional settings
        foreach (mods[mi]) begin
            for (int f2 = 0; f2 < mods[mi]; f2++) begin
                foreach (f1s[fi]) begin
                    do_load(100 + f2, f1s[fi], f2, mods[mi], 1'b0);
                    expv = f1s[fi] * mods[mi] + f2;
                    run_sum(100 + f2, mods[mi] * ONE1, s, bad);
                    run_sum(100 + f2, mods[mi] * ONE1, s2, bad2);
                    check(s - expv <= 2 && expv - s <= 2, "R5 one-period sum", s, expv);
                    check(s + s2 - 2*expv <= 2 && 2*expv - s - s2 <= 2,
                          "R5 two-period sum", s + s2, 2*expv);
                    check(bad + bad2 == 0, "R4 window per cycle", bad + bad2, 0);
                end
            end
        end

        // R7: legal boundaries, with the output window at the edges
        do_load(23, 15, 12, 13, 1'b0);
        check(cfg_err == 1'b0, "R7 INT 23 narrow legal", int'(cfg_err), 0);
        run_sum(23, 64, s, bad);
        check(bad == 0, "R4 window at INT 23", bad, 0);
        do_load(32767, 15, 12, 13, 1'b0);
        check(cfg_err == 1'b0, "R7 INT 32767 narrow legal", int'(cfg_err), 0);
        do_load(75, 15, 12, 13, 1'b1);
        check(cfg_err == 1'b0, "R7 INT 75 wide legal", int'(cfg_err), 0);
        do_load(65535, 15, 12, 13, 1'b1);
        check(cfg_err == 1'b0, "R7 INT 65535 wide legal", int'(cfg_err), 0);
        check(int'(div_out) == 65535, "R3 value after load at max", int'(div_out), 65535);
        run_sum(65535, 64, s, bad);
        check(bad == 0, "R4 window at INT 65535", bad, 0);
        do_load(100, 1, 1, 2, 1'b0);
        check(cfg_err == 1'b0, "R7 MOD2 2 FRAC2 1 legal", int'(cfg_err), 0);

        // R7, R8: illegal loads while output varies
        do_load(100, 7, 2, 3, 1'b0);
        for (int k = 0; k < 6; k++) begin
            repeat (5) @(negedge clk);
            hold_v = int'(div_out);
            case (k)
                0: do_load(22, 3, 0, 2, 1'b0);
                1: do_load(74, 3, 0, 2, 1'b1);
                2: do_load(32768, 3, 0, 2, 1'b0);
                3: do_load(100, 3, 0, 1, 1'b0);
                4: do_load(100, 3, 3, 3, 1'b0);
                default: do_load(100, 3, 0, 0, 1'b0);
            endcase
            check(cfg_err == 1'b1, "R7 illegal setting flagged", int'(cfg_err), 1);
            check(int'(div_out) == hold_v, "R8 output held at load", int'(div_out), hold_v);
            moved = 0;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                if (int'(div_out) != hold_v) moved++;
            end
            check(moved == 0, "R8 output frozen", moved, 0);
            do_load(100, 7, 2, 3, 1'b0);
            check(cfg_err == 1'b0 && int'(div_out) == 100, "R3 recovery after error",
                  int'(div_out), 100);
        end

        // R9: reload mid-sequence reproduces the first sequence
        do_load(300, 11, 5, 7, 1'b0);
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            seq_a[i] = int'(div_out);
        end
        repeat (37) @(negedge clk);
        do_load(300, 11, 5, 7, 1'b0);
        moved = 0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (int'(div_out) != seq_a[i]) moved++;
        end
        check(moved == 0, "R9 reload restarts sequence", moved, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule